// File: doc/BRIEF.md
# Streaming Pixel Square-Accumulate Unit

This block takes two image streams of equal geometry and produces a third. For every pixel and every channel it squares the 8-bit unsigned sample of the first stream and adds the 8-bit unsigned sample at the same position in the second stream, the running accumulator image. The 16-bit unsigned result leaves on its own output stream. The accumulator input is only read: the caller gets the updated accumulator from the output stream and stores it wherever it needs to.

One stream word carries `NPC` pixels side by side, where `NPC` is 1, 2, 4 or 8. Each pixel holds `NCH` channels, either 1 or 3. Every channel of every pixel in a word has its own multiply-add lane, so a full word is processed on each clock. A beat is taken only when both inputs offer one and the output path can move, so the two images stay paired under backpressure. Frame height and width are runtime inputs bounded by compile-time maximums. An internal beat counter marks the last output beat of each frame.

Top module: `sq_accum_stream`

## Requirements
- R1: For each lane, the output sample equals the accumulator-input sample plus the square of the first-input sample from the same lane of the same beat. Every channel is computed independently of the others.
- R2: Inputs are 8-bit unsigned and outputs are 16-bit unsigned, with no saturation. The extreme case of 255 squared plus 255 yields exactly 65280 (16'hFF00), and no output lane ever exceeds 65280.
- R3: Lane l = p*NCH + c holds pixel p, channel c. Its input sample sits at bits [8l+7:8l] of each input word and its result at bits [16l+15:16l] of the output word, so pixel 0 and, within a pixel, channel 0 take the lowest bits.
- R4: `NPC` may be 1, 2, 4 or 8 and `NCH` may be 1 or 3. The frame width `cols_i` is given in pixels, must be a multiple of `NPC`, and gives `cols_i/NPC` beats per row.
- R5: A beat is consumed from both inputs in the same cycle, and only when both valids are high and the pipeline can advance. A valid on one input alone is not consumed, and it produces no output.
- R6: While `y_valid_o` is high and `y_ready_i` is low, the output data and end-of-frame flag hold steady and neither input is accepted.
- R7: When not stalled, a beat accepted at clock edge k appears on the output after edge k+2, two cycles of latency, and one beat is accepted on every clock.
- R8: `y_eof_o` is high exactly on the output beat carrying the last pixel of the frame. That is beat number `rows_i*cols_i/NPC` of the frame, and `y_eof_o` is never high without `y_valid_o`.
- R9: After an end-of-frame beat, the beat counter restarts, so the next frame is marked again on its own last beat.
- R10: While `rst_ni` is low, and after reset until data is accepted, `y_valid_o` and `y_eof_o` are 0. With no input valid, `a_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rows_i | input | $clog2(MAX_ROWS+1) | Frame height in rows, held stable during a frame |
| cols_i | input | $clog2(MAX_COLS+1) | Frame width in pixels, a multiple of NPC |
| a_valid_i | input | 1 | First image beat valid |
| a_data_i | input | NPC*NCH*8 | First image samples, squared |
| a_ready_o | output | 1 | First image beat taken |
| b_valid_i | input | 1 | Accumulator image beat valid |
| b_data_i | input | NPC*NCH*8 | Accumulator image samples |
| b_ready_o | output | 1 | Accumulator image beat taken |
| y_valid_o | output | 1 | Result beat valid |
| y_data_o | output | NPC*NCH*16 | Result samples |
| y_eof_o | output | 1 | Last beat of frame |
| y_ready_i | input | 1 | Downstream accepts result |

## Verification
The risky overlap is between output backpressure and input acceptance. In the same cycle, the pipeline may be holding a finished result and also be offered a new input pair, and the frame counter must step only for the beat that was really taken. The bench provokes this with an irregular `y_ready_i` pattern during a multi-row frame while both inputs stay valid. It judges the result by the order and values of the popped results, the end-of-frame position, the held output during stalls, and ready staying low in those cycles.

// File: rtl/sq_accum_pkg.sv
package sq_accum_pkg;
  localparam int PIX_W = 8;
  localparam int ACC_W = 16;
  localparam int ACC_MAX = 65280;  // 255*255 + 255
  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/sq_accum_lane.sv
module sq_accum_lane
  import sq_accum_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  pix_t a_i,
  input  pix_t b_i,
  output acc_t y_o
);
  acc_t sq_q;
  pix_t b_q;

  // stage 1: square, stage 2: add
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q <= '0;
      b_q  <= '0;
      y_o  <= '0;
    end else if (en_i) begin
      sq_q <= acc_t'(a_i) * acc_t'(a_i);
      b_q  <= b_i;
      y_o  <= sq_q + acc_t'(b_q);
    end
  end
endmodule

// File: rtl/sq_accum_frame_cnt.sv
module sq_accum_frame_cnt #(
  parameter  int NPC      = 1,
  parameter  int MAX_ROWS = 1080,
  parameter  int MAX_COLS = 1920,
  localparam int ROW_W    = $clog2(MAX_ROWS + 1),
  localparam int COL_W    = $clog2(MAX_COLS + 1),
  localparam int SH       = $clog2(NPC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  output logic             last_o
);
  logic [COL_W-1:0] bpr, col_q;
  logic [ROW_W-1:0] row_q;
  logic             col_end, row_end;

  assign bpr     = cols_i >> SH;
  assign col_end = (col_q == bpr - COL_W'(1));
  assign row_end = (row_q == rows_i - ROW_W'(1));
  assign last_o  = col_end && row_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step_i) begin
      if (col_end) begin
        col_q <= '0;
        row_q <= row_end ? '0 : row_q + ROW_W'(1);
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/sq_accum_stream.sv
module sq_accum_stream
  import sq_accum_pkg::*;
#(
  parameter  int NPC      = 1,
  parameter  int NCH      = 1,
  parameter  int MAX_ROWS = 1080,
  parameter  int MAX_COLS = 1920,
  localparam int LANES    = NPC * NCH,
  localparam int IN_W     = LANES * PIX_W,
  localparam int OUT_W    = LANES * ACC_W,
  localparam int ROW_W    = $clog2(MAX_ROWS + 1),
  localparam int COL_W    = $clog2(MAX_COLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic             a_valid_i,
  input  logic [IN_W-1:0]  a_data_i,
  output logic             a_ready_o,
  input  logic             b_valid_i,
  input  logic [IN_W-1:0]  b_data_i,
  output logic             b_ready_o,
  output logic             y_valid_o,
  output logic [OUT_W-1:0] y_data_o,
  output logic             y_eof_o,
  input  logic             y_ready_i
);
  logic adv, take, last;
  logic s1_v_q, s2_v_q, s1_eof_q, s2_eof_q;

  // whole pipeline moves together; a stalled output freezes both stages
  assign adv       = !s2_v_q || y_ready_i;
  assign take      = a_valid_i && b_valid_i && adv;
  assign a_ready_o = adv && b_valid_i;
  assign b_ready_o = adv && a_valid_i;

  sq_accum_frame_cnt #(
    .NPC     (NPC),
    .MAX_ROWS(MAX_ROWS),
    .MAX_COLS(MAX_COLS)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(take),
    .rows_i(rows_i),
    .cols_i(cols_i),
    .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q   <= 1'b0;
      s2_v_q   <= 1'b0;
      s1_eof_q <= 1'b0;
      s2_eof_q <= 1'b0;
    end else if (adv) begin
      s1_v_q   <= take;
      s2_v_q   <= s1_v_q;
      s1_eof_q <= take && last;
      s2_eof_q <= s1_eof_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sq_accum_lane u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (adv),
      .a_i   (a_data_i[l*PIX_W +: PIX_W]),
      .b_i   (b_data_i[l*PIX_W +: PIX_W]),
      .y_o   (y_data_o[l*ACC_W +: ACC_W])
    );
  end

  assign y_valid_o = s2_v_q;
  assign y_eof_o   = s2_eof_q;
endmodule

// File: rtl/sq_accum_checker.sv
module sq_accum_checker #(
  parameter int LANES = 1,
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             a_valid_i,
  input logic             a_ready_o,
  input logic             b_valid_i,
  input logic             b_ready_o,
  input logic             y_valid_o,
  input logic [OUT_W-1:0] y_data_o,
  input logic             y_eof_o,
  input logic             y_ready_i
);
  p_joint_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o) == (b_valid_i && b_ready_o));

  p_hold_out_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i) |=> (y_valid_o && $stable(y_data_o) && $stable(y_eof_o)));

  p_no_take_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o && !y_ready_i) |-> (!a_ready_o && !b_ready_o));

  p_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o) |=> ##1 y_valid_o);

  p_eof_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_eof_o |-> y_valid_o);

  for (genvar g = 0; g < LANES; g++) begin : g_bound
    p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      y_valid_o |-> (y_data_o[16*g +: 16] <= 16'd65280));
  end
endmodule

bind sq_accum_stream sq_accum_checker #(
  .LANES(LANES),
  .OUT_W(OUT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_valid_i(a_valid_i),
  .a_ready_o(a_ready_o),
  .b_valid_i(b_valid_i),
  .b_ready_o(b_ready_o),
  .y_valid_o(y_valid_o),
  .y_data_o (y_data_o),
  .y_eof_o  (y_eof_o),
  .y_ready_i(y_ready_i)
);

// File: tb/sq_accum_stream_test.sv
module sq_accum_stream_test;
  localparam int NPC   = 2;
  localparam int NCH   = 3;
  localparam int MAXR  = 8;
  localparam int MAXC  = 16;
  localparam int LANES = NPC * NCH;
  localparam int IN_W  = LANES * 8;
  localparam int OUT_W = LANES * 16;
  localparam int ROW_W = $clog2(MAXR + 1);
  localparam int COL_W = $clog2(MAXC + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [ROW_W-1:0] rows_i = '0;
  logic [COL_W-1:0] cols_i = '0;
  logic             a_valid_i = 1'b0, b_valid_i = 1'b0;
  logic [IN_W-1:0]  a_data_i = '0, b_data_i = '0;
  logic             a_ready_o, b_ready_o, y_valid_o, y_eof_o;
  logic [OUT_W-1:0] y_data_o;
  logic             y_ready_i = 1'b1;

  int checks = 0, fails = 0, cyc = 0, sc = 0;
  int beat_idx = 0, frame_beats = 1;
  bit stall_en = 0, done = 0;

  logic [OUT_W-1:0] q_d[$];
  bit               q_eof[$];
  int               q_cyc[$];
  bit               q_tight[$];

  sq_accum_stream #(.NPC(NPC), .NCH(NCH), .MAX_ROWS(MAXR), .MAX_COLS(MAXC)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rows_i(rows_i), .cols_i(cols_i),
    .a_valid_i(a_valid_i), .a_data_i(a_data_i), .a_ready_o(a_ready_o),
    .b_valid_i(b_valid_i), .b_data_i(b_data_i), .b_ready_o(b_ready_o),
    .y_valid_o(y_valid_o), .y_data_o(y_data_o), .y_eof_o(y_eof_o), .y_ready_i(y_ready_i));

  always #4 clk_i = ~clk_i;  // 125 MHz
  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string req, input logic [OUT_W-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] a, b);
    logic [OUT_W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[16*l +: 16] = 16'(a[8*l +: 8]) * 16'(a[8*l +: 8]) + 16'(b[8*l +: 8]);
    return r;
  endfunction

  // driver: offer a pair, push expected result once the pair is taken
  task automatic send(input logic [IN_W-1:0] a, b, input logic [OUT_W-1:0] exp);
    @(negedge clk_i);
    a_valid_i = 1'b1; b_valid_i = 1'b1; a_data_i = a; b_data_i = b;
    #2;
    while (!(a_ready_o && b_ready_o)) begin @(negedge clk_i); #2; end
    q_d.push_back(exp);
    q_eof.push_back(beat_idx == frame_beats - 1);
    q_cyc.push_back(cyc);
    q_tight.push_back(!stall_en);
    beat_idx = (beat_idx == frame_beats - 1) ? 0 : beat_idx + 1;
    @(posedge clk_i);
  endtask

  task automatic idle();
    @(negedge clk_i);
    a_valid_i = 1'b0; b_valid_i = 1'b0;
  endtask

  task automatic frame(input int r, input int c);
    rows_i = ROW_W'(r); cols_i = COL_W'(c);
    frame_beats = r * c / NPC; beat_idx = 0;
  endtask

  task automatic drain();
    while (q_d.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // downstream ready pattern
  always @(negedge clk_i) begin
    sc++;
    y_ready_i = stall_en ? (((sc * 7) % 5) < 3) : 1'b1;
  end

  // monitor
  logic [OUT_W-1:0] held_d;
  bit               held_eof, was_stalled = 0;
  initial begin
    forever begin
      @(negedge clk_i); #3;
      if (rst_ni) begin
        if (was_stalled) begin
          chk(y_valid_o && y_data_o == held_d && y_eof_o == held_eof, "R6 hold",
              y_data_o, held_d);
        end
        if (y_valid_o && !y_ready_i)
          chk(!a_ready_o && !b_ready_o, "R6 no take", {a_ready_o, b_ready_o}, 0);
        was_stalled = y_valid_o && !y_ready_i;
        held_d = y_data_o; held_eof = y_eof_o;
        if (!y_valid_o) chk(!y_eof_o, "R8 eof without valid", y_eof_o, 0);
        if (y_valid_o && y_ready_i) begin
          if (q_d.size() == 0) chk(0, "R5 spurious output", y_data_o, 0);
          else begin
            logic [OUT_W-1:0] e; bit ee, t; int c0;
            e = q_d.pop_front(); ee = q_eof.pop_front();
            c0 = q_cyc.pop_front(); t = q_tight.pop_front();
            chk(y_data_o == e, "R1 data", y_data_o, e);
            chk(y_eof_o == ee, "R8 eof", y_eof_o, ee);
            if (t) chk(cyc - c0 == 2, "R7 latency", cyc - c0, 2);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!y_valid_o && !y_eof_o, "R10 reset outputs", {y_valid_o, y_eof_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk(!y_valid_o && !a_ready_o, "R10 idle", {y_valid_o, a_ready_o}, 0);

    // R3 lane placement, R7 back-to-back, R8 eof on beat 4
    frame(2, 4);
    send(48'h00_00_00_00_00_03, '0, 96'h0000_0000_0000_0000_0000_0009);     // R3 lane0
    send(48'h00_00_05_00_00_00, '0, 96'h0000_0000_0019_0000_0000_0000);     // R3 pixel1 ch0
    send(48'h02_00_00_00_00_00, 48'h01_00_00_00_00_00,
         96'h0005_0000_0000_0000_0000_0000);                                 // R3 pixel1 ch2
    send(48'h10_20_30_40_50_60, 48'h01_02_03_04_05_06,
         model(48'h10_20_30_40_50_60, 48'h01_02_03_04_05_06));               // R1 channels
    idle(); drain();

    // R2 extremes, R9 restart
    frame(1, 6);
    send({6{8'hFF}}, {6{8'hFF}}, {6{16'hFF00}});                             // R2 65280
    send({6{8'hFF}}, '0, {6{16'hFE01}});
    send('0, {6{8'hFF}}, {6{16'h00FF}});
    idle(); drain();

    // R6 backpressure while inputs stay valid, R4 multi-row width
    stall_en = 1;
    frame(3, 8);
    for (int i = 0; i < 12; i++) begin
      logic [IN_W-1:0] a, b;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      send(a, b, model(a, b));
    end
    idle(); drain();
    stall_en = 0;
    repeat (2) @(negedge clk_i);

    // R5 lone valid is not taken
    frame(1, 2);
    @(negedge clk_i);
    a_valid_i = 1'b1; a_data_i = 48'h07_00_00_00_00_04; b_valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #2; chk(!a_ready_o, "R5 lone a", a_ready_o, 0);
      @(negedge clk_i);
    end
    chk(!y_valid_o, "R5 no output", y_valid_o, 0);
    send(48'h07_00_00_00_00_04, 48'h00_00_00_00_00_01,
         96'h0031_0000_0000_0000_0000_0011);
    idle(); drain();

    done = 1;
    finish_run();
  end
endmodule